// File: doc/BRIEF.md
# Floating-Point Class Mask Tester

This unit takes one floating-point operand in half or single precision and works out which of ten categories it falls in. The categories are signaling NaN, quiet NaN, infinity of either sign, normal of either sign, denormal of either sign, and zero of either sign. It then tests that category against a 10-bit mask and returns one bit. The bit is 1 when the mask selects the operand's category.

A caller presents the operand, a format select and the mask, and raises `in_valid` for one cycle. The answer appears on `out_match` one clock later, qualified by `out_valid`. A new operand may be presented every cycle. Denormals are never flushed, so they always land in a denormal category.

Top module: `fp_class_tester`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` and `out_match` are 0.
- R2: `out_valid` in a cycle equals `in_valid` sampled at the previous rising clock edge.
- R3: `out_match` is the mask bit selected by the category of the operand sampled with `in_valid`, one cycle later. It is 0 whenever `out_valid` is 0. A mask of zero always gives 0.
- R4: The mask bit positions are fixed as follows:
  - bit 9: positive infinity
  - bit 8: positive normal
  - bit 7: positive denormal
  - bit 6: positive zero
  - bit 5: negative zero
  - bit 4: negative denormal
  - bit 3: negative normal
  - bit 2: negative infinity
  - bit 1: quiet NaN
  - bit 0: signaling NaN
- R5: An operand with an all-ones exponent and a nonzero fraction is a NaN. It is quiet when the top fraction bit is 1, and signaling when that bit is 0. A quiet NaN does not match mask 0x001, and a signaling NaN does not match mask 0x002. Examples: f32 0x7fc00000 and f16 0x7e00 are quiet; f32 0x7f800001 and f16 0x7c01 are signaling.
- R6: An all-ones exponent with a zero fraction is an infinity, and the sign bit picks the category. Examples: f32 0x7f800000 and 0xff800000, and f16 0x7c00 and 0xfc00.
- R7: A zero exponent with a nonzero fraction is a denormal of its sign, with no flushing (f16 0x0001 and 0x8001). A zero exponent with a zero fraction is a zero of its sign (f16 0x0000 and 0x8000). Mask 0x060 matches both zeros.
- R8: `fmt_sel` = 0 selects f16, which uses `data_in[15:0]` and ignores `data_in[31:16]`. `fmt_sel` = 1 selects f32, which uses all 32 bits.
- R9: Every operand falls in exactly one category. Mask 0x3ff therefore always gives 1. Mask 0x1f8 gives 1 for every zero, denormal and normal value, and 0 for every NaN and infinity.
- R10: Any other exponent is a normal of its sign. Examples: f16 0x3c00 is positive and 0xbc00 is negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand, format and mask are presented this cycle |
| fmt_sel | input | 1 | 0 = f16 in low half, 1 = f32 |
| data_in | input | 32 | Operand bits |
| mask_in | input | 10 | Category select mask |
| out_valid | output | 1 | Result is present |
| out_match | output | 1 | Mask selects the operand's category |

## Verification
The bench aims at the borders between categories, since each border has a typical failure:
- **NaN versus infinity.** A design that tests only the exponent calls every NaN an infinity.
- **Quiet versus signaling NaN.** A design that reads the wrong fraction bit reports quiet NaNs as signaling.
- **Denormal versus zero.** A design that flushes denormals, or ignores the fraction when the exponent is zero, merges denormals into zero.
- **Sign handling.** A sign slip swaps bits 2 to 9 around the middle of the mask.
- **Format selection.** Garbage in the upper half in f16 mode shows up when the design takes its fields from the wrong width.

Random operands are biased towards all-ones and all-zero exponents so that these borders are crossed often.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;

    // Category index equals the mask bit that selects it.
    typedef enum logic [3:0] {
        CLS_SNAN  = 4'd0,
        CLS_QNAN  = 4'd1,
        CLS_NINF  = 4'd2,
        CLS_NNORM = 4'd3,
        CLS_NSUB  = 4'd4,
        CLS_NZERO = 4'd5,
        CLS_PZERO = 4'd6,
        CLS_PSUB  = 4'd7,
        CLS_PNORM = 4'd8,
        CLS_PINF  = 4'd9
    } fp_cls_e;

    localparam int unsigned CLS_COUNT = 10;

    typedef enum logic {
        FMT_HALF   = 1'b0,
        FMT_SINGLE = 1'b1
    } fp_fmt_e;

    // Format-independent summary of an operand's fields.
    typedef struct packed {
        logic sign;
        logic exp_max;
        logic exp_min;
        logic frac_nz;
        logic frac_top;
    } fp_fields_t;

endpackage

// File: rtl/fpcls_unpack.sv
module fpcls_unpack
    import fpcls_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output fp_fields_t            fields
);
    localparam int unsigned SIGN_POS = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_bits;
    logic [FRAC_W-1:0] frac_bits;

    always_comb begin
        exp_bits        = word[SIGN_POS-1:FRAC_W];
        frac_bits       = word[FRAC_W-1:0];
        fields.sign     = word[SIGN_POS];
        fields.exp_max  = &exp_bits;
        fields.exp_min  = ~|exp_bits;
        fields.frac_nz  = |frac_bits;
        fields.frac_top = frac_bits[FRAC_W-1];
    end
endmodule

// File: rtl/fpcls_decode.sv
module fpcls_decode
    import fpcls_pkg::*;
(
    input  fp_fields_t           fields,
    output logic [CLS_COUNT-1:0] cls_onehot
);
    fp_cls_e cls;

    always_comb begin
        if (fields.exp_max) begin
            if (!fields.frac_nz)      cls = fields.sign ? CLS_NINF : CLS_PINF;
            else if (fields.frac_top) cls = CLS_QNAN;
            else                      cls = CLS_SNAN;
        end else if (fields.exp_min) begin
            if (fields.frac_nz)       cls = fields.sign ? CLS_NSUB : CLS_PSUB;
            else                      cls = fields.sign ? CLS_NZERO : CLS_PZERO;
        end else begin
            cls = fields.sign ? CLS_NNORM : CLS_PNORM;
        end
    end

    always_comb begin
        cls_onehot = '0;
        cls_onehot[cls] = 1'b1;
    end
endmodule

// File: rtl/fp_class_tester.sv
module fp_class_tester
    import fpcls_pkg::*;
#(
    parameter int unsigned HALF_EXP_W    = 5,
    parameter int unsigned HALF_FRAC_W   = 10,
    parameter int unsigned SINGLE_EXP_W  = 8,
    parameter int unsigned SINGLE_FRAC_W = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        fmt_sel,
    input  logic [31:0] data_in,
    input  logic [9:0]  mask_in,
    output logic        out_valid,
    output logic        out_match
);
    localparam int unsigned HALF_W   = HALF_EXP_W + HALF_FRAC_W + 1;
    localparam int unsigned SINGLE_W = SINGLE_EXP_W + SINGLE_FRAC_W + 1;

    fp_fields_t            fmt_fields [2];
    fp_fields_t            sel_fields;
    logic [CLS_COUNT-1:0]  cls_onehot;
    logic                  hit;
    fp_fmt_e               fmt;

    // One field extractor per supported format.
    for (genvar g = 0; g < 2; g++) begin : g_fmt
        if (g == 0) begin : g_half
            fpcls_unpack #(.EXP_W(HALF_EXP_W), .FRAC_W(HALF_FRAC_W)) u_unpack (
                .word   (data_in[HALF_W-1:0]),
                .fields (fmt_fields[g])
            );
        end else begin : g_single
            fpcls_unpack #(.EXP_W(SINGLE_EXP_W), .FRAC_W(SINGLE_FRAC_W)) u_unpack (
                .word   (data_in[SINGLE_W-1:0]),
                .fields (fmt_fields[g])
            );
        end
    end

    always_comb begin
        fmt = fp_fmt_e'(fmt_sel);
        unique case (fmt)
            FMT_HALF:   sel_fields = fmt_fields[0];
            FMT_SINGLE: sel_fields = fmt_fields[1];
            default:    sel_fields = fmt_fields[1];
        endcase
    end

    fpcls_decode u_decode (
        .fields     (sel_fields),
        .cls_onehot (cls_onehot)
    );

    always_comb hit = |(cls_onehot & mask_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_match <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_match <= in_valid & hit;
        end
    end
endmodule

// File: rtl/fpcls_checker.sv
module fpcls_checker
    import fpcls_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [9:0]           mask_in,
    input logic [CLS_COUNT-1:0] cls_onehot,
    input logic                 out_valid,
    input logic                 out_match
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_MATCH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_match); // R3
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_in == 10'h000) |=> !out_match); // R3
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_in == 10'h3ff) |=> out_match); // R9
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $countones(cls_onehot) == 1); // R9
endmodule

bind fp_class_tester fpcls_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mask_in    (mask_in),
    .cls_onehot (cls_onehot),
    .out_valid  (out_valid),
    .out_match  (out_match)
);

// File: tb/sim_fp_class_tester.sv
module sim_fp_class_tester;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        fmt_sel = 1'b0;
    logic [31:0] data_in = '0;
    logic [9:0]  mask_in = '0;
    logic        out_valid;
    logic        out_match;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk; // 250 MHz

    fp_class_tester u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
        .data_in(data_in), .mask_in(mask_in),
        .out_valid(out_valid), .out_match(out_match)
    );

    // Category index from the field rules in R5, R6, R7 and R10.
    function automatic int ref_class(input logic f32, input logic [31:0] d);
        logic s; int e; int emax; logic [22:0] fr; logic top;
        if (f32) begin
            s = d[31]; e = int'(d[30:23]); emax = 255; fr = d[22:0]; top = d[22];
        end else begin
            s = d[15]; e = int'(d[14:10]); emax = 31; fr = {13'b0, d[9:0]}; top = d[9];
        end
        if (e == emax) begin
            if (fr == 0) return s ? 2 : 9;
            return top ? 1 : 0;
        end
        if (e == 0) begin
            if (fr == 0) return s ? 5 : 6;
            return s ? 4 : 7;
        end
        return s ? 3 : 8;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic run(input logic f32, input logic [31:0] d, input logic [9:0] m,
                       input logic exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1; fmt_sel = f32; data_in = d; mask_in = m;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, out_valid, 1'b1);
        chk(tag, out_match, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", out_valid, 1'b0);
        chk("R1 reset match", out_match, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset valid", out_valid, 1'b0);
        chk("R1 post-reset match", out_match, 1'b0);

        // R5 NaNs
        run(1, 32'h7fc00000, 10'h002, 1, "R5 f32 qnan");
        run(1, 32'h7f800001, 10'h001, 1, "R5 f32 snan");
        run(1, 32'h7fc00000, 10'h001, 0, "R5 f32 qnan vs snan mask");
        run(1, 32'h7f800001, 10'h002, 0, "R5 f32 snan vs qnan mask");
        run(0, 32'h00007e00, 10'h002, 1, "R5 f16 qnan");
        run(0, 32'h00007c01, 10'h001, 1, "R5 f16 snan");
        // R6 infinities
        run(1, 32'h7f800000, 10'h200, 1, "R6 f32 +inf");
        run(1, 32'hff800000, 10'h004, 1, "R6 f32 -inf");
        run(1, 32'hff800000, 10'h200, 0, "R6 f32 -inf vs +inf mask");
        run(0, 32'h00007c00, 10'h200, 1, "R6 f16 +inf");
        run(0, 32'h0000fc00, 10'h004, 1, "R6 f16 -inf");
        // R10 normals
        run(0, 32'h00003c00, 10'h100, 1, "R10 f16 +norm");
        run(0, 32'h0000bc00, 10'h008, 1, "R10 f16 -norm");
        run(1, 32'h3f800000, 10'h100, 1, "R10 f32 +1.0");
        run(1, 32'hbf800000, 10'h008, 1, "R10 f32 -1.0");
        // R7 denormals and zeros
        run(0, 32'h00000001, 10'h080, 1, "R7 f16 +denorm");
        run(0, 32'h00008001, 10'h010, 1, "R7 f16 -denorm");
        run(0, 32'h00000001, 10'h040, 0, "R7 f16 denorm not zero");
        run(0, 32'h00000000, 10'h040, 1, "R7 f16 +zero");
        run(0, 32'h00008000, 10'h020, 1, "R7 f16 -zero");
        run(0, 32'h00008000, 10'h060, 1, "R7 -zero mask 0x060");
        run(0, 32'h00000000, 10'h060, 1, "R7 +zero mask 0x060");
        run(1, 32'h00000001, 10'h080, 1, "R7 f32 +denorm");
        // R9 combined masks
        run(0, 32'h00000000, 10'h1f8, 1, "R9 +zero mask 0x1f8");
        run(0, 32'h00003c00, 10'h1f8, 1, "R9 +norm mask 0x1f8");
        run(0, 32'h00007e00, 10'h1f8, 0, "R9 qnan mask 0x1f8");
        run(0, 32'h00007c00, 10'h1f8, 0, "R9 +inf mask 0x1f8");
        run(1, 32'h7f800001, 10'h3ff, 1, "R9 full mask");
        // R3 empty mask
        run(1, 32'h3f800000, 10'h000, 0, "R3 empty mask");
        // R4 mapping: one-bit mask at the wrong position
        run(1, 32'h3f800000, 10'h200, 0, "R4 +norm vs bit 9");
        // R8 upper half ignored in f16
        run(0, 32'hdead0001, 10'h080, 1, "R8 f16 upper ignored denorm");
        run(0, 32'hffff3c00, 10'h100, 1, "R8 f16 upper ignored norm");
        run(0, 32'h7f800000, 10'h040, 1, "R8 f16 low zero under f32 inf");

        // R2, R3: idle cycle
        @(negedge clk);
        in_valid = 1'b0; mask_in = 10'h3ff; data_in = 32'h3f800000;
        @(negedge clk);
        chk("R2 idle valid", out_valid, 1'b0);
        chk("R3 idle match", out_match, 1'b0);

        // R3 random
        for (int i = 0; i < 800; i++) begin
            logic [31:0] d;
            logic [9:0]  m;
            logic        f;
            int          sel;
            d = $urandom;
            f = 1'($urandom);
            sel = int'($urandom % 5);
            if (sel == 1) begin
                if (f) d[30:23] = 8'hff; else d[14:10] = 5'h1f;
            end else if (sel == 2) begin
                if (f) d[30:23] = 8'h00; else d[14:10] = 5'h00;
            end else if (sel == 3) begin
                if (f) d[30:0] = {8'hff, 23'h0}; else d[14:0] = 15'h0;
            end
            if ($urandom % 2 == 0) m = 10'(1 << ($urandom % 10));
            else m = 10'($urandom);
            run(f, d, m, m[ref_class(f, d)], "R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule